// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This peripheral holds one 16-bit counter. Depending on its configuration, the counter acts as a capture timer, an auto-reload timer that counts up only or up and down, a bit-clock source for a serial port, or a divider that drives a square wave onto a pin. An oscillator-rate clock runs the block. Two enables, supplied from outside, set its time base. `mc_en` pulses once per machine cycle, which is twelve oscillator periods. `st_en` pulses once per state time, which is two oscillator periods. Two external pins are sampled once per machine cycle. `cnt_pin` supplies events for counter function. `trig_pin` supplies a capture or reload trigger, or the count direction.

A small state machine decodes the control and mode registers into one operating state. The states are HALT, CAPT, RELD, UPDN, BAUD and CLKO. On every clock the FSM takes the next state from the current register contents, so a register write takes effect one clock later. Transitions, in priority order: run clear goes to HALT; either serial-clock select goes to BAUD; output enable with timer function goes to CLKO; capture select goes to CAPT; down enable goes to UPDN; otherwise the FSM goes to RELD. Any state can move to any other in one clock.

Top module: `mm_timer16`

## Requirements
- R1: After reset every register reads 0, and `clk_out`, `irq`, `tx_ovf` and `rx_ovf` are low.
- R2: Register addresses are 0 control, 1 mode, 2 count low, 3 count high, 4 reload low, 5 reload high. The control bits are: 7 overflow flag, 6 external flag, 5 receive-clock select, 4 transmit-clock select, 3 external enable, 2 run, 1 counter select, 0 capture select. The mode register keeps only bit 1 (clock-out enable) and bit 0 (down enable), and its other bits read 0.
- R3: In timer function in CAPT, RELD or UPDN, the count advances once per `mc_en` pulse, and `st_en` has no effect.
- R4: In counter function (bit 1 = 1), the count advances once for each high sample of `cnt_pin` followed by a low sample, where the samples are taken on `mc_en`. A steady pin does not advance it.
- R5: In RELD, a tick at 0xFFFF loads the reload value and sets the overflow flag.
- R6: In RELD with external enable set, a sampled falling edge on `trig_pin` loads the reload value and sets the external flag.
- R7: In CAPT with external enable set, a sampled falling edge on `trig_pin` copies the count into the reload register and sets the external flag. At 0xFFFF the count wraps to 0 and sets the overflow flag, with no reload.
- R8: In UPDN, a sampled high on `trig_pin` counts up, and the count reloads at 0xFFFF. A sampled low counts down: when the count equals the reload value it becomes 0xFFFF. Both events set the overflow flag and toggle the external flag.
- R9: `irq` = overflow flag OR (external flag AND NOT down enable). The hardware only sets the flags, apart from the UPDN toggle. Only a control write clears them.
- R10: In BAUD the count advances on `st_en` and reloads at 0xFFFF without setting the overflow flag. Each rollover gives a one-cycle pulse on `rx_ovf` and/or `tx_ovf`, according to the select bits. A trigger edge with external enable set sets the external flag without a reload.
- R11: In CLKO, and in BAUD with clock-out enable set and timer function, each rollover toggles `clk_out`. The count advances on `st_en` and the overflow flag is not set.
- R12: A set serial-clock select overrides capture select and down enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| mc_en | input | 1 | Machine-cycle enable |
| st_en | input | 1 | State-time enable |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Trigger / direction input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tx_ovf | output | 1 | Transmit bit-clock rollover pulse |
| rx_ovf | output | 1 | Receive bit-clock rollover pulse |
| irq | output | 1 | Interrupt request |
| clk_out | output | 1 | Square-wave output |

## Verification
The bench checks reload at the 0xFFFF boundary, and it checks the down-count underflow when the count equals the reload value. A design that compares against zero, or reloads one tick late, would read back a wrong count. The bench holds the external flag high in up/down mode and checks that `irq` stays low. It also checks that rollovers in BAUD and CLKO leave the overflow flag clear. A design that left the flag unmasked, or flagged every rollover, would raise an interrupt. It sets capture select together with a serial-clock select, and it checks that a trigger edge in BAUD sets the flag without a reload. A wrong priority would move the count or capture it. In counter function the bench holds `cnt_pin` steady and checks that the count stays put. A level-sensitive count would run on.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_CAPT,
        ST_RELD,
        ST_UPDN,
        ST_BAUD,
        ST_CLKO
    } mmt_state_e;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNTL = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNTH = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLDL = 3'd4;
    localparam logic [ADDR_W-1:0] A_RLDH = 3'd5;

    localparam int B_TF   = 7;
    localparam int B_EXF  = 6;
    localparam int B_RSEL = 5;
    localparam int B_TSEL = 4;
    localparam int B_EXEN = 3;
    localparam int B_RUN  = 2;
    localparam int B_CT   = 1;
    localparam int B_CAP  = 0;
endpackage

// File: rtl/mmt_pin_sampler.sv
module mmt_pin_sampler #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_en,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] fall_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_o[g]  <= 1'b0;
                fall_o[g] <= 1'b0;
            end else begin
                fall_o[g] <= smp_en & lvl_o[g] & ~pin_i[g];
                if (smp_en) lvl_o[g] <= pin_i[g];
            end
        end
    end
endmodule

// File: rtl/mmt_mode_fsm.sv
module mmt_mode_fsm
    import mmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       rsel,
    input  logic       tsel,
    input  logic       cap_sel,
    input  logic       ext_cnt,
    input  logic       co_en,
    input  logic       dn_en,
    output mmt_state_e state_o,
    output logic       fast_o,
    output logic       flag_o,
    output logic       ext_ok_o
);
    mmt_state_e state_q, state_d;

    always_comb begin
        if (!run)                   state_d = ST_HALT;
        else if (rsel || tsel)      state_d = ST_BAUD;
        else if (co_en && !ext_cnt) state_d = ST_CLKO;
        else if (cap_sel)           state_d = ST_CAPT;
        else if (dn_en)             state_d = ST_UPDN;
        else                        state_d = ST_RELD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        fast_o   = 1'b0;
        flag_o   = 1'b0;
        ext_ok_o = 1'b0;
        unique case (state_q)
            ST_HALT: ;
            ST_CAPT: begin flag_o = 1'b1; ext_ok_o = 1'b1; end
            ST_RELD: begin flag_o = 1'b1; ext_ok_o = 1'b1; end
            ST_UPDN: flag_o = 1'b1;
            ST_BAUD: begin fast_o = 1'b1; ext_ok_o = 1'b1; end
            ST_CLKO: begin fast_o = 1'b1; ext_ok_o = 1'b1; end
            default: ;
        endcase
    end

    assign state_o = state_q;

    AST_BAUD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (rsel || tsel)) |=> (state_q == ST_BAUD)); // R12
endmodule

// File: rtl/mmt_core.sv
module mmt_core
    import mmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_en,
    input  logic              st_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              cnt_fall,
    input  logic              trig_fall,
    input  logic              trig_lvl,
    input  mmt_state_e        state_i,
    input  logic              fast_i,
    input  logic              flag_i,
    input  logic              ext_ok_i,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [1:0]        mode_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  rld_o,
    output logic              clk_out_o,
    output logic              tx_ovf_o,
    output logic              rx_ovf_o,
    output logic              irq_o
);
    logic tf, exf, rsel, tsel, exen, run, ct, cap;
    logic co_en, dn_en;
    logic [CNT_W-1:0] cnt, rld, cnt_nx;
    logic co, tx_q, rx_q;
    logic tick, roll, cnt_max, at_rld, ext_evt;
    logic wr_ctrl, wr_mode, wr_cntl, wr_cnth, wr_rldl, wr_rldh;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_mode = bus_wr && (bus_addr == A_MODE);
    assign wr_cntl = bus_wr && (bus_addr == A_CNTL);
    assign wr_cnth = bus_wr && (bus_addr == A_CNTH);
    assign wr_rldl = bus_wr && (bus_addr == A_RLDL);
    assign wr_rldh = bus_wr && (bus_addr == A_RLDH);

    assign tick    = ct ? cnt_fall : (fast_i ? st_en : mc_en);
    assign cnt_max = &cnt;
    assign at_rld  = (cnt == rld);
    assign ext_evt = exen && trig_fall && ext_ok_i;

    always_comb begin
        roll   = 1'b0;
        cnt_nx = cnt;
        unique case (state_i)
            ST_HALT: ;
            ST_CAPT: if (tick) begin
                roll   = cnt_max;
                cnt_nx = cnt + 1'b1;
            end
            ST_UPDN: if (tick) begin
                if (trig_lvl) begin
                    roll   = cnt_max;
                    cnt_nx = cnt_max ? rld : cnt + 1'b1;
                end else begin
                    roll   = at_rld;
                    cnt_nx = at_rld ? '1 : cnt - 1'b1;
                end
            end
            default: if (tick) begin
                roll   = cnt_max;
                cnt_nx = cnt_max ? rld : cnt + 1'b1;
            end
        endcase
        if (ext_evt && state_i == ST_RELD) cnt_nx = rld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {tf, exf, rsel, tsel, exen, run, ct, cap} <= '0;
            co_en <= 1'b0;
            dn_en <= 1'b0;
            cnt   <= '0;
            rld   <= '0;
            co    <= 1'b0;
            tx_q  <= 1'b0;
            rx_q  <= 1'b0;
        end else begin
            if (wr_ctrl) {tf, exf, rsel, tsel, exen, run, ct, cap} <= bus_wdata;
            if (roll && flag_i) tf <= 1'b1;
            if (ext_evt) exf <= 1'b1;
            if (roll && state_i == ST_UPDN) exf <= ~exf;
            if (wr_mode) {co_en, dn_en} <= bus_wdata[1:0];

            cnt <= cnt_nx;
            if (wr_cntl) cnt[BYTE_W-1:0]     <= bus_wdata;
            if (wr_cnth) cnt[CNT_W-1:BYTE_W] <= bus_wdata;

            if (ext_evt && state_i == ST_CAPT) rld <= cnt;
            if (wr_rldl) rld[BYTE_W-1:0]     <= bus_wdata;
            if (wr_rldh) rld[CNT_W-1:BYTE_W] <= bus_wdata;

            if (roll && fast_i && co_en && !ct) co <= ~co;
            tx_q <= roll && (state_i == ST_BAUD) && tsel;
            rx_q <= roll && (state_i == ST_BAUD) && rsel;
        end
    end

    assign ctrl_o    = {tf, exf, rsel, tsel, exen, run, ct, cap};
    assign mode_o    = {co_en, dn_en};
    assign cnt_o     = cnt;
    assign rld_o     = rld;
    assign clk_out_o = co;
    assign tx_ovf_o  = tx_q;
    assign rx_ovf_o  = rx_q;
    assign irq_o     = tf | (exf & ~dn_en);

    AST_RELD_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_RELD && !ct && !mc_en && !ext_evt && !wr_cntl && !wr_cnth)
        |=> $stable(cnt)); // R3
    AST_NO_ROLL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_i == ST_BAUD || state_i == ST_CLKO) && !wr_ctrl) |=> !$rose(tf)); // R10
    AST_FLAG_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tf) |-> $past(wr_ctrl)); // R9
    AST_CLKOUT_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        !roll |=> $stable(co)); // R11
endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
    import mmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_en,
    input  logic              st_en,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              tx_ovf,
    output logic              rx_ovf,
    output logic              irq,
    output logic              clk_out
);
    localparam int NPIN = 2;
    localparam int P_CNT = 0;
    localparam int P_TRG = 1;

    logic [NPIN-1:0] pin_lvl, pin_fall;
    logic            cnt_lvl_unused;
    mmt_state_e      state;
    logic            fast, flag_ok, ext_ok;
    logic [BYTE_W-1:0] ctrl;
    logic [1:0]        mode;
    logic [CNT_W-1:0]  cnt, rld;

    assign cnt_lvl_unused = pin_lvl[P_CNT];

    mmt_pin_sampler #(.N(NPIN)) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (mc_en),
        .pin_i  ({trig_pin, cnt_pin}),
        .lvl_o  (pin_lvl),
        .fall_o (pin_fall)
    );

    mmt_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl[B_RUN]),
        .rsel     (ctrl[B_RSEL]),
        .tsel     (ctrl[B_TSEL]),
        .cap_sel  (ctrl[B_CAP]),
        .ext_cnt  (ctrl[B_CT]),
        .co_en    (mode[1]),
        .dn_en    (mode[0]),
        .state_o  (state),
        .fast_o   (fast),
        .flag_o   (flag_ok),
        .ext_ok_o (ext_ok)
    );

    mmt_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_en     (mc_en),
        .st_en     (st_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_fall  (pin_fall[P_CNT]),
        .trig_fall (pin_fall[P_TRG]),
        .trig_lvl  (pin_lvl[P_TRG]),
        .state_i   (state),
        .fast_i    (fast),
        .flag_i    (flag_ok),
        .ext_ok_i  (ext_ok),
        .ctrl_o    (ctrl),
        .mode_o    (mode),
        .cnt_o     (cnt),
        .rld_o     (rld),
        .clk_out_o (clk_out),
        .tx_ovf_o  (tx_ovf),
        .rx_ovf_o  (rx_ovf),
        .irq_o     (irq)
    );

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl;
            A_MODE:  bus_rdata = {{(BYTE_W-2){1'b0}}, mode};
            A_CNTL:  bus_rdata = cnt[BYTE_W-1:0];
            A_CNTH:  bus_rdata = cnt[CNT_W-1:BYTE_W];
            A_RLDL:  bus_rdata = rld[BYTE_W-1:0];
            A_RLDH:  bus_rdata = rld[CNT_W-1:BYTE_W];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/sim_mm_timer16.sv
module sim_mm_timer16;
    logic clk = 1'b0, rst_n = 1'b0;
    logic mc_en = 1'b0, st_en = 1'b0, cnt_pin = 1'b0, trig_pin = 1'b0;
    logic bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic tx_ovf, rx_ovf, irq, clk_out;
    int checks = 0, errors = 0, rx_seen = 0, tx_seen = 0, cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mm_timer16 u0 (.clk(clk), .rst_n(rst_n), .mc_en(mc_en), .st_en(st_en),
        .cnt_pin(cnt_pin), .trig_pin(trig_pin), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
        .irq(irq), .clk_out(clk_out));

    always @(negedge clk) begin
        if (rx_ovf) rx_seen++;
        if (tx_ovf) tx_seen++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic br(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic r16(input logic [2:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        br(a, lo); br(a + 3'd1, hi); v = {hi, lo};
    endtask

    task automatic w16(input logic [2:0] a, input logic [15:0] v);
        bw(a, v[7:0]); bw(a + 3'd1, v[15:8]);
    endtask

    task automatic mcp(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); mc_en = 1'b1;
            @(negedge clk); mc_en = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic stp(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); st_en = 1'b1;
            @(negedge clk); st_en = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 6; a++) begin
            br(3'(a), d); chk("R1 reg after reset", 16'(d), 16'h0);
        end
        chk("R1 outputs after reset", {12'h0, irq, clk_out, tx_ovf, rx_ovf}, 16'h0);
    endtask

    task automatic t_regmap;
        logic [7:0] d; logic [15:0] v;
        bw(3'd1, 8'hFF); br(3'd1, d); chk("R2 mode keeps bits 1:0", 16'(d), 16'h0003);
        bw(3'd1, 8'h00);
        w16(3'd2, 16'hCDAB); r16(3'd2, v); chk("R2 count bytes", v, 16'hCDAB);
        w16(3'd4, 16'hA55A); r16(3'd4, v); chk("R2 reload bytes", v, 16'hA55A);
    endtask

    task automatic t_timer_reload;
        logic [7:0] d; logic [15:0] v;
        w16(3'd2, 16'h0010); bw(3'd0, 8'h04);
        mcp(5); r16(3'd2, v); chk("R3 one step per machine cycle", v, 16'h0015);
        w16(3'd4, 16'h1234); w16(3'd2, 16'hFFFE);
        mcp(2); r16(3'd2, v); chk("R5 reload after FFFF", v, 16'h1234);
        br(3'd0, d); chk("R5 overflow flag set", 16'(d), 16'h0084);
        chk("R9 irq from overflow", 16'(irq), 16'h1);
        stp(4); r16(3'd2, v); chk("R3 state-time enable ignored", v, 16'h1234);
        mcp(1); br(3'd0, d); chk("R9 flag held by hardware", 16'(d), 16'h0084);
        bw(3'd0, 8'h04); chk("R9 write clears irq", 16'(irq), 16'h0);
        bw(3'd0, 8'h00);
    endtask

    task automatic t_trig_reload;
        logic [7:0] d; logic [15:0] v;
        trig_pin = 1'b1; mcp(1);
        w16(3'd2, 16'h0050); w16(3'd4, 16'h7000); bw(3'd0, 8'h0C);
        trig_pin = 1'b0; mcp(1);
        r16(3'd2, v); chk("R6 trigger reload", v, 16'h7000);
        br(3'd0, d); chk("R6 external flag", 16'(d), 16'h004C);
        chk("R9 irq from external flag", 16'(irq), 16'h1);
        bw(3'd0, 8'h00);
    endtask

    task automatic t_capture;
        logic [7:0] d; logic [15:0] v;
        trig_pin = 1'b1; mcp(1);
        w16(3'd2, 16'h0100); w16(3'd4, 16'h0000); bw(3'd0, 8'h0D);
        mcp(2); trig_pin = 1'b0; mcp(1); mcp(1);
        r16(3'd2, v); chk("R7 count runs on", v, 16'h0104);
        r16(3'd4, v); chk("R7 captured value", v, 16'h0103);
        br(3'd0, d); chk("R7 external flag", 16'(d), 16'h004D);
        w16(3'd2, 16'hFFFF); bw(3'd0, 8'h0D); mcp(1);
        r16(3'd2, v); chk("R7 wrap to zero", v, 16'h0000);
        br(3'd0, d); chk("R7 overflow flag", 16'(d), 16'h008D);
        r16(3'd4, v); chk("R7 no reload in capture", v, 16'h0103);
        bw(3'd0, 8'h00);
    endtask

    task automatic t_updown;
        logic [7:0] d; logic [15:0] v;
        trig_pin = 1'b0; mcp(1);
        bw(3'd1, 8'h01); w16(3'd4, 16'h0003); w16(3'd2, 16'h0005); bw(3'd0, 8'h04);
        mcp(3); r16(3'd2, v); chk("R8 underflow at reload value", v, 16'hFFFF);
        br(3'd0, d); chk("R8 flags after underflow", 16'(d), 16'h00C4);
        bw(3'd0, 8'h44); chk("R9 external flag masked in up/down", 16'(irq), 16'h0);
        trig_pin = 1'b1; mcp(3);
        r16(3'd2, v); chk("R8 count up and reload", v, 16'h0003);
        br(3'd0, d); chk("R8 external flag toggles", 16'(d), 16'h0084);
        bw(3'd0, 8'h00); bw(3'd1, 8'h00);
    endtask

    task automatic t_baud;
        logic [7:0] d; logic [15:0] v;
        rx_seen = 0; tx_seen = 0;
        w16(3'd4, 16'hFFFD); w16(3'd2, 16'hFFFE);
        bw(3'd0, 8'h2D);
        trig_pin = 1'b1; mcp(1); trig_pin = 1'b0; mcp(1);
        r16(3'd2, v); chk("R10 trigger gives no reload, R12 no capture", v, 16'hFFFE);
        r16(3'd4, v); chk("R12 reload untouched", v, 16'hFFFD);
        stp(5); r16(3'd2, v); chk("R10 reload on rollover", v, 16'hFFFD);
        chk("R10 receive pulses", 16'(rx_seen), 16'd2);
        chk("R10 no transmit pulses", 16'(tx_seen), 16'd0);
        br(3'd0, d); chk("R10 external flag only", 16'(d), 16'h006D);
        bw(3'd0, 8'h00);
    endtask

    task automatic t_clkout;
        logic [7:0] d; logic [15:0] v;
        bw(3'd1, 8'h02); w16(3'd4, 16'hFFFE); w16(3'd2, 16'hFFFE); bw(3'd0, 8'h04);
        stp(2); chk("R11 clock out high after rollover", 16'(clk_out), 16'h1);
        stp(2); chk("R11 clock out low after second rollover", 16'(clk_out), 16'h0);
        mcp(2); r16(3'd2, v); chk("R11 machine cycles ignored", v, 16'hFFFE);
        br(3'd0, d); chk("R11 no overflow flag", 16'(d), 16'h0004);
        bw(3'd0, 8'h00); bw(3'd1, 8'h00);
    endtask

    task automatic t_counter;
        logic [15:0] v;
        cnt_pin = 1'b0; mcp(1);
        w16(3'd2, 16'h0007); bw(3'd0, 8'h06);
        for (int i = 0; i < 3; i++) begin
            cnt_pin = 1'b1; mcp(1); cnt_pin = 1'b0; mcp(1);
        end
        r16(3'd2, v); chk("R4 one step per falling edge", v, 16'h000A);
        mcp(3); stp(3); r16(3'd2, v); chk("R4 steady pin holds count", v, 16'h000A);
        bw(3'd0, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regmap;
        t_timer_reload;
        t_trig_reload;
        t_capture;
        t_updown;
        t_baud;
        t_clkout;
        t_counter;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule